// File: doc/BRIEF.md
# Phase-Shifted Multi-Channel PWM Generator

This block drives a bank of pulse-width modulated outputs from one shared, free-running 12-bit period counter. Every channel owns a start point and a stop point inside the 4096-step period, so pulses on different channels can be staggered across the period to spread switching current. A pulse may also straddle the period boundary. Each channel also has two override flags. One forces the pin permanently active. The other forces it permanently inactive and wins over the first.

Channel settings are loaded through a byte-wide write port that addresses one channel and one of four byte fields. Writes land in a staging copy. The running copy takes the staged values only at the period wrap, or at once while the block is asleep, so a pulse in flight is never cut short. The counter advances on an externally prescaled tick. A global invert control flips every pin. A sleep control freezes the counter and parks every pin at its inactive level.

Top module: `pwm_phase_bank`

## Requirements
- R1: `count_out` advances by exactly one on each clock with `tick` high and `sleep` low, wraps from 4095 to 0, and holds its value on every other clock.
- R2: With both flags clear, a channel is active exactly when (count − start) mod 4096 < (stop − start) mod 4096. The pulse rises at the start point and falls at the stop point, and it wraps across the period boundary when stop < start.
- R3: With both flags clear and start equal to stop, the channel stays inactive for the whole period.
- R4: With the force-on flag set and the force-off flag clear, the channel is active on every count.
- R5: The force-off flag holds the channel inactive on every count, even when the force-on flag is also set.
- R6: Field select 0 writes start bits 7:0, 1 writes start bits 11:8 from data bits 3:0, 2 writes stop bits 7:0, and 3 writes stop bits 11:8 from data bits 3:0. On fields 1 and 3, data bit 4 sets or clears the force-on or the force-off flag. A write to field 0 or field 2 clears the matching flag.
- R7: Writes made while the counter runs take effect on the clock at which the counter wraps from 4095 to 0. The running period keeps the old settings up to that point, and a write on that same clock waits for the following wrap.
- R8: With `invert` high, every pin shows the complement of its channel's active state, and the inactive level is high.
- R9: While `sleep` is high, the counter holds, every pin drives its inactive level (equal to `invert`), and staged settings reach the running copy one clock after they are written.
- R10: After reset the counter is 0, every channel has start = stop = 0 with both flags set, and every pin is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count enable |
| sleep | input | 1 | Freeze the counter and park the pins |
| invert | input | 1 | Invert every pin |
| wr_en | input | 1 | Write strobe for the settings port |
| wr_chan | input | $clog2(NUM_CH) | Channel addressed by the write |
| wr_field | input | 2 | Byte field: 0 start low, 1 start high, 2 stop low, 3 stop high |
| wr_data | input | 8 | Write data byte |
| pwm_out | output | NUM_CH | Pin levels, one per channel |
| count_out | output | 12 | Shared period counter |

## Verification
The hardest situation to reach is a settings write landing in the middle of a running period. The old pulse shape must persist up to the wrap and the new one must start exactly on it. The stimulus lets the counter run to mid-period, rewrites several channels with tick-free write cycles, then sweeps on through the wrap and a whole further period. Each count is compared against a bench model that keeps its own staged and running copies. Wrapped pulses, equal start and stop, and both flags together are set up under sleep so that every channel shows a different case within one full sweep of all 4096 counts.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;

    localparam int CNT_W    = 12;
    localparam int BYTE_W   = 8;
    localparam int HI_W     = CNT_W - BYTE_W;
    localparam int FLAG_BIT = 4;

    typedef enum logic [1:0] {
        FLD_START_LO = 2'd0,
        FLD_START_HI = 2'd1,
        FLD_STOP_LO  = 2'd2,
        FLD_STOP_HI  = 2'd3
    } field_e;

    typedef struct packed {
        logic             force_on;
        logic             force_off;
        logic [CNT_W-1:0] start_pt;
        logic [CNT_W-1:0] stop_pt;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{
        force_on:  1'b1,
        force_off: 1'b1,
        start_pt:  '0,
        stop_pt:   '0
    };

    // Active level of one channel at a given count (before inversion).
    function automatic logic chan_level(input chan_cfg_t c, input logic [CNT_W-1:0] cnt);
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] span;
        pos  = cnt - c.start_pt;
        span = c.stop_pt - c.start_pt;
        if (c.force_off)
            return 1'b0;
        else if (c.force_on)
            return 1'b1;
        else
            return (pos < span);
    endfunction

    // Merge one byte write into a channel's staged settings.
    function automatic chan_cfg_t merge_write(input chan_cfg_t c, input field_e f,
                                              input logic [BYTE_W-1:0] d);
        chan_cfg_t r;
        r = c;
        case (f)
            FLD_START_LO: begin
                r.start_pt[BYTE_W-1:0] = d;
                r.force_on             = 1'b0;
            end
            FLD_START_HI: begin
                r.start_pt[CNT_W-1:BYTE_W] = d[HI_W-1:0];
                r.force_on                 = d[FLAG_BIT];
            end
            FLD_STOP_LO: begin
                r.stop_pt[BYTE_W-1:0] = d;
                r.force_off           = 1'b0;
            end
            default: begin
                r.stop_pt[CNT_W-1:BYTE_W] = d[HI_W-1:0];
                r.force_off               = d[FLAG_BIT];
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwmb_counter.sv
module pwmb_counter #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          sleep,
    output logic [CW-1:0] count,
    output logic          wrap
);
    localparam logic [CW-1:0] LAST = '1;

    logic step;
    assign step = tick && !sleep;
    assign wrap = step && (count == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (step)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/pwmb_chan_regs.sv
module pwmb_chan_regs
    import pwmb_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int CH_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_chan,
    input  field_e            wr_field,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              load,
    output chan_cfg_t         active
);
    localparam logic [IDX_W-1:0] MY_IDX = CH_ID[IDX_W-1:0];

    chan_cfg_t staged;
    logic      hit;

    assign hit = wr_en && (wr_chan == MY_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= CFG_RESET;
            active <= CFG_RESET;
        end else begin
            if (load)
                active <= staged;
            if (hit)
                staged <= merge_write(staged, wr_field, wr_data);
        end
    end
endmodule

// File: rtl/pwmb_chan_out.sv
module pwmb_chan_out
    import pwmb_pkg::*;
(
    input  chan_cfg_t        cfg,
    input  logic [CNT_W-1:0] count,
    input  logic             sleep,
    input  logic             invert,
    output logic             pin
);
    logic lvl;

    always_comb begin
        lvl = sleep ? 1'b0 : chan_level(cfg, count);
        pin = lvl ^ invert;
    end
endmodule

// File: rtl/pwm_phase_bank.sv
module pwm_phase_bank
    import pwmb_pkg::*;
#(
    parameter  int NUM_CH = 16,
    localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              sleep,
    input  logic              invert,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_chan,
    input  logic [1:0]        wr_field,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [CNT_W-1:0]  count_out
);
    logic   wrap;
    logic   load;
    field_e field;

    assign field = field_e'(wr_field);
    assign load  = sleep || wrap;

    pwmb_counter #(.CW(CNT_W)) cnt_i (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .sleep (sleep),
        .count (count_out),
        .wrap  (wrap)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        chan_cfg_t cfg;

        pwmb_chan_regs #(.IDX_W(IDX_W), .CH_ID(ch)) regs_i (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en),
            .wr_chan  (wr_chan),
            .wr_field (field),
            .wr_data  (wr_data),
            .load     (load),
            .active   (cfg)
        );

        pwmb_chan_out out_i (
            .cfg    (cfg),
            .count  (count_out),
            .sleep  (sleep),
            .invert (invert),
            .pin    (pwm_out[ch])
        );
    end
endmodule

// File: rtl/pwmb_checker.sv
module pwmb_checker #(
    parameter int NUM_CH = 16,
    parameter int CW     = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              sleep,
    input logic              invert,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [CW-1:0]     count_out
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !sleep) |=> (count_out == $past(count_out) + 1'b1)); // R1

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick || sleep) |=> $stable(count_out)); // R1

    AST_SLEEP_PARK: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (pwm_out == {NUM_CH{invert}})); // R9

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count_out == '0 && pwm_out == {NUM_CH{invert}})); // R10

    AST_INVERT_FLIP: assert property (@(posedge clk) disable iff (rst)
        ($rose(invert) && $stable(count_out) && !sleep && !$past(sleep) && !$past(rst))
        |-> (pwm_out == ~$past(pwm_out))); // R8
endmodule

bind pwm_phase_bank pwmb_checker #(.NUM_CH(NUM_CH), .CW(pwmb_pkg::CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .sleep     (sleep),
    .invert    (invert),
    .pwm_out   (pwm_out),
    .count_out (count_out)
);

// File: tb/pwm_phase_bank_tb_top.sv
module pwm_phase_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 16;
    localparam int MOD  = 4096;
    localparam int LAST = 4095;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        sleep = 1'b0;
    logic        invert = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_chan = '0;
    logic [1:0]  wr_field = '0;
    logic [7:0]  wr_data = '0;
    logic [NCH-1:0] pwm_out;
    logic [11:0] count_out;

    pwm_phase_bank #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst(rst), .tick(tick), .sleep(sleep), .invert(invert),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_field(wr_field), .wr_data(wr_data),
        .pwm_out(pwm_out), .count_out(count_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;

    // bench model: staged and running copies
    int s_on[NCH], s_off[NCH], a_on[NCH], a_off[NCH];
    bit s_fon[NCH], s_foff[NCH], a_fon[NCH], a_foff[NCH];
    int m_cnt;

    function automatic void model_reset();
        for (int c = 0; c < NCH; c++) begin
            s_on[c] = 0; s_off[c] = 0; s_fon[c] = 1; s_foff[c] = 1;
            a_on[c] = 0; a_off[c] = 0; a_fon[c] = 1; a_foff[c] = 1;
        end
        m_cnt = 0;
    endfunction

    function automatic void model_edge(input bit t);
        int c;
        if (sleep || (t && m_cnt == LAST)) begin
            for (int k = 0; k < NCH; k++) begin
                a_on[k] = s_on[k]; a_off[k] = s_off[k];
                a_fon[k] = s_fon[k]; a_foff[k] = s_foff[k];
            end
        end
        if (wr_en) begin
            c = int'(wr_chan);
            case (wr_field)
                2'd0: begin s_on[c] = (s_on[c] & 32'hF00) | int'(wr_data); s_fon[c] = 0; end
                2'd1: begin s_on[c] = (s_on[c] & 32'h0FF) | (int'(wr_data[3:0]) << 8); s_fon[c] = wr_data[4]; end
                2'd2: begin s_off[c] = (s_off[c] & 32'hF00) | int'(wr_data); s_foff[c] = 0; end
                default: begin s_off[c] = (s_off[c] & 32'h0FF) | (int'(wr_data[3:0]) << 8); s_foff[c] = wr_data[4]; end
            endcase
        end
        if (t && !sleep) m_cnt = (m_cnt + 1) % MOD;
    endfunction

    function automatic logic [NCH-1:0] expect_pins();
        logic [NCH-1:0] e;
        for (int c = 0; c < NCH; c++) begin
            bit lvl;
            if (sleep)          lvl = 0;
            else if (a_foff[c]) lvl = 0;
            else if (a_fon[c])  lvl = 1;
            else lvl = (((m_cnt - a_on[c]) % MOD + MOD) % MOD) < (((a_off[c] - a_on[c]) % MOD + MOD) % MOD);
            e[c] = lvl ^ invert;
        end
        return e;
    endfunction

    task automatic check_now(input string tag);
        logic [NCH-1:0] e;
        e = expect_pins();
        n_vec++;
        if (int'(count_out) != m_cnt) begin
            n_bad++;
            $display("FAIL %s count_out actual=%0d expected=%0d", tag, count_out, m_cnt);
        end
        n_vec++;
        if (pwm_out !== e) begin
            n_bad++;
            $display("FAIL %s pwm_out actual=%h expected=%h (count %0d)", tag, pwm_out, e, m_cnt);
        end
    endtask

    task automatic cyc(input bit t, input string tag);
        tick = t;
        @(posedge clk);
        model_edge(t);
        @(negedge clk);
        check_now(tag);
        wr_en = 1'b0;
        tick  = 1'b0;
    endtask

    task automatic wr(input int ch, input int fld, input int d, input string tag);
        wr_en = 1'b1; wr_chan = 4'(ch); wr_field = 2'(fld); wr_data = 8'(d);
        cyc(1'b0, tag);
    endtask

    task automatic set_chan(input int ch, input int on, input int off,
                            input bit fon, input bit foff, input string tag);
        wr(ch, 0, on & 255, tag);
        wr(ch, 1, ((on >> 8) & 15) | (fon ? 16 : 0), tag);
        wr(ch, 2, off & 255, tag);
        wr(ch, 3, ((off >> 8) & 15) | (foff ? 16 : 0), tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_now("R10");
        run(10, "R10");

        // configure under sleep; ch0 keeps force-on, only force-off cleared
        sleep = 1'b1;
        wr(0, 3, 0, "R4");
        set_chan(1, 12'h123, 12'h123, 0, 0, "R3");
        set_chan(2, 100, 900, 1, 0, "R4");
        set_chan(3, 100, 900, 1, 1, "R5");
        for (int c = 4; c < NCH; c++)
            set_chan(c, c * 256, (c * 256 + (c * 613 + 7) % MOD) % MOD, 0, 0, "R9");
        run(5, "R9");
        sleep = 1'b0;
        run(MOD + 5, "R2");

        // sparse ticks
        for (int i = 0; i < 100; i++) begin
            cyc(1'b1, "R1");
            cyc(1'b0, "R1");
            cyc(1'b0, "R1");
        end

        // mid-period rewrite
        while (m_cnt != 2000) cyc(1'b1, "R7");
        set_chan(4, 4000, 50, 0, 0, "R7");
        set_chan(9, 10, 10, 0, 0, "R7");
        set_chan(12, 0, 2048, 0, 0, "R7");
        while (m_cnt != LAST) cyc(1'b1, "R7");
        wr(6, 0, 8'h55, "R7");
        wr_en = 1'b1; wr_chan = 4'd7; wr_field = 2'd2; wr_data = 8'h11;
        cyc(1'b1, "R7");
        run(MOD + 3, "R7");

        // flag via high byte, cleared via low byte
        sleep = 1'b1;
        wr(5, 1, 16, "R6");
        cyc(1'b0, "R6");
        sleep = 1'b0;
        run(50, "R6");
        sleep = 1'b1;
        wr(5, 0, 8'h40, "R6");
        wr(8, 3, 16, "R6");
        cyc(1'b0, "R6");
        sleep = 1'b0;
        run(MOD + 2, "R6");

        // invert
        invert = 1'b1;
        cyc(1'b0, "R8");
        run(MOD + 2, "R8");

        // sleep with invert
        sleep = 1'b1;
        run(20, "R9");
        sleep = 1'b0;
        run(20, "R9");

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule